// File: doc/BRIEF.md
# SECAM Line Sequence Controller

This block produces the per-line control signals for a SECAM colour encoder. It steps once per video line. In line-locked tuning, the step comes from a line strobe supplied by an upstream sync separator. In crystal tuning, the step comes from a line pulse that the block derives from its own blue reference tick.

On every line step the block does four things:
- It alternates the red/blue colour-difference select.
- It advances a three-line subcarrier start-phase pattern.
- It updates the gates that pass one colour channel or the other. A colour-kill input can blank both gates.
- It updates an identification-enable flag, which is allowed only in one tuning mode.

At the first line of each vertical blanking interval the block inverts the sense of the phase pattern. On that same line it opens two back-to-back reference calibration windows: two lines for the red reference, then two lines for the blue reference.

Two counters divide the reference ticks by 272 (blue) and 282 (red). Each produces a line-rate pulse for the reference loops. An external half-line-rate reset input lets several encoders align their colour sequence. It forces the select to red on the next clock.

Top module: `secam_line_seq`

## Requirements
- R1: After reset `sel_red` is 1. Each line step inverts `sel_red`.
- R2: While `ext_half_rst` is 1, `sel_red` becomes 1 on the next clock edge, with priority over a line step. On that same edge the gates take `gate_red` = not `colour_kill` and `gate_blue` = 0.
- R3: `phase_flip` updates only on a line step. With the inversion state clear, successive steps after reset give 0, 0, 1 and then repeat.
- R4: The first line step taken while `vblank` is 1, after `vblank` has been 0, inverts the sense of the whole three-line phase pattern. The inversion persists until the next blanking interval.
- R5: That same first blanking step sets `cal_red` for two steps. The following two steps set `cal_blue`. Both are 0 otherwise, and the two are never 1 together.
- R6: `tune_mode` encoding: 00 = line-locked without identification, 01 = line-locked with identification, 1x = crystal. On a line step, `ident_en` becomes 1 only when the mode is 01 and `vblank` is 1. When the mode is not 01, `ident_en` is 0 from the next clock edge.
- R7: On a line step, `gate_red` takes the value of `sel_red` AND NOT `colour_kill`, and `gate_blue` takes the value of NOT `sel_red` AND NOT `colour_kill`. The `sel_red` used here is its updated value. With `colour_kill` at 1, both gates are 0.
- R8: `line_ref_b` pulses for one clock after every 272nd `ref_b_tick`. `line_ref_r` pulses for one clock after every 282nd `ref_r_tick`.
- R9: In crystal mode the line step is the `line_ref_b` pulse, and `line_stb` has no effect on any output.
- R10: After the synchronous active-low reset, `phase_flip`, `cal_red`, `cal_blue`, `ident_en`, `gate_red` and `gate_blue` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-clock line strobe from the sync separator |
| vblank | input | 1 | Vertical blanking flag |
| ext_half_rst | input | 1 | External half-line-rate alignment; high forces red |
| colour_kill | input | 1 | Blanks both colour-difference gates |
| tune_mode | input | 2 | 00 line-locked, 01 line-locked with identification, 1x crystal |
| ref_b_tick | input | 1 | Blue reference clock tick (clock enable) |
| ref_r_tick | input | 1 | Red reference clock tick (clock enable) |
| sel_red | output | 1 | 1 = red difference line, 0 = blue difference line |
| gate_red | output | 1 | Pass enable for the red difference channel |
| gate_blue | output | 1 | Pass enable for the blue difference channel |
| phase_flip | output | 1 | Subcarrier restart with 180 degree shift on this line |
| cal_red | output | 1 | Red reference calibration window |
| cal_blue | output | 1 | Blue reference calibration window |
| ident_en | output | 1 | Identification sawtooth enable |
| line_ref_b | output | 1 | Line-rate pulse from the blue reference divider |
| line_ref_r | output | 1 | Line-rate pulse from the red reference divider |

## Verification
A wrong phase counter or inversion state appears on `phase_flip` within three line steps. It appears either as a broken 0-0-1 rhythm or as the wrong polarity after a blanking edge. A stuck or missed blanking-edge detector moves or drops the `cal_red`/`cal_blue` windows, and that is visible on the first blanking line. Select and gate errors show on the next step, because `sel_red` must alternate every line. Divider miscounts shift the `line_ref_b` pulse by whole ticks, and in crystal mode they also delay every line step.

// File: rtl/secam_seq_pkg.sv
package secam_seq_pkg;

    typedef enum logic [1:0] {
        TUNE_LINE     = 2'b00,
        TUNE_LINE_ID  = 2'b01,
        TUNE_XTAL     = 2'b10,
        TUNE_XTAL_ALT = 2'b11
    } tune_e;

    typedef struct packed {
        logic sel_red;
        logic gate_r;
        logic gate_b;
        logic ident;
    } chan_st_t;

endpackage

// File: rtl/ref_line_div.sv
module ref_line_div #(
    parameter int DIV = 272
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic pulse
);
    localparam int CW = $clog2(DIV);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick) begin
            if (st_q.cnt == CW'(DIV - 1)) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R8: a line pulse is a single clock wide
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/phase_seq.sv
module phase_seq #(
    parameter int PHASE_LEN = 3,
    parameter int CAL_LINES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic vblank,
    output logic flip,
    output logic cal_red,
    output logic cal_blue
);
    localparam int PW   = $clog2(PHASE_LEN);
    localparam int CALT = 2 * CAL_LINES;
    localparam int QW   = $clog2(CALT + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          vinv;
        logic          seen;
        logic [QW-1:0] pos;
        logic          flip;
        logic          cal_r;
        logic          cal_b;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   first_blank;

    always_comb begin
        st_d        = st_q;
        first_blank = 1'b0;
        if (!vblank) st_d.seen = 1'b0;
        if (step) begin
            first_blank = vblank && !st_q.seen;
            st_d.seen   = vblank;
            if (first_blank) begin
                st_d.vinv = ~st_q.vinv;
                st_d.pos  = QW'(1);
            end else if (st_q.pos != '0) begin
                st_d.pos = (st_q.pos == QW'(CALT)) ? '0 : st_q.pos + QW'(1);
            end
            st_d.flip  = (st_q.cnt == PW'(PHASE_LEN - 1)) ^ st_d.vinv;
            st_d.cnt   = (st_q.cnt == PW'(PHASE_LEN - 1)) ? '0 : st_q.cnt + PW'(1);
            st_d.cal_r = (st_d.pos != '0) && (st_d.pos <= QW'(CAL_LINES));
            st_d.cal_b = (st_d.pos > QW'(CAL_LINES));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flip     = st_q.flip;
    assign cal_red  = st_q.cal_r;
    assign cal_blue = st_q.cal_b;

    // R3: the phase flag moves only with a line step
    p_flip_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(flip));
    // R5: the red and blue windows never overlap
    p_cal_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_red && cal_blue));
    // R5: the first blanking step opens the red window
    p_cal_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && vblank && !st_q.seen) |=> cal_red);

endmodule

// File: rtl/chan_sel.sv
module chan_sel
    import secam_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  ext_rst,
    input  logic  kill,
    input  logic  vblank,
    input  tune_e mode,
    output logic  sel_red,
    output logic  gate_r,
    output logic  gate_b,
    output logic  ident
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ext_rst) begin
            st_d.sel_red = 1'b1;
            st_d.gate_r  = !kill;
            st_d.gate_b  = 1'b0;
        end else if (step) begin
            st_d.sel_red = ~st_q.sel_red;
            st_d.gate_r  = !kill && !st_q.sel_red;
            st_d.gate_b  = !kill && st_q.sel_red;
        end
        if (step) st_d.ident = (mode == TUNE_LINE_ID) && vblank;
        if (mode != TUNE_LINE_ID) st_d.ident = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sel_red: 1'b1, gate_r: 1'b0, gate_b: 1'b0, ident: 1'b0};
        else        st_q <= st_d;
    end

    assign sel_red = st_q.sel_red;
    assign gate_r  = st_q.gate_r;
    assign gate_b  = st_q.gate_b;
    assign ident   = st_q.ident;

    // R1: every step without an external reset alternates the channel
    p_sel_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ext_rst) |=> (sel_red != $past(sel_red)));
    // R2: external reset lands on red
    p_ext_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> sel_red);
    // R7: kill blanks both gates
    p_kill_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && kill) |=> (!gate_r && !gate_b));
    // R6: identification only in its own mode
    p_ident_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != TUNE_LINE_ID) |=> !ident);

endmodule

// File: rtl/secam_line_seq.sv
module secam_line_seq
    import secam_seq_pkg::*;
#(
    parameter int DIV_B     = 272,
    parameter int DIV_R     = 282,
    parameter int PHASE_LEN = 3,
    parameter int CAL_LINES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    input  logic       vblank,
    input  logic       ext_half_rst,
    input  logic       colour_kill,
    input  logic [1:0] tune_mode,
    input  logic       ref_b_tick,
    input  logic       ref_r_tick,
    output logic       sel_red,
    output logic       gate_red,
    output logic       gate_blue,
    output logic       phase_flip,
    output logic       cal_red,
    output logic       cal_blue,
    output logic       ident_en,
    output logic       line_ref_b,
    output logic       line_ref_r
);
    localparam int NDIV = 2;
    localparam int DIVS [NDIV] = '{DIV_B, DIV_R};

    logic [NDIV-1:0] ref_tick;
    logic [NDIV-1:0] ref_line;
    tune_e           mode;
    logic            xtal;
    logic            step;

    assign ref_tick = {ref_r_tick, ref_b_tick};
    assign mode     = tune_e'(tune_mode);

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        ref_line_div #(.DIV(DIVS[g])) i_div (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (ref_tick[g]),
            .pulse (ref_line[g])
        );
    end

    always_comb begin
        xtal = tune_mode[1];
        step = xtal ? ref_line[0] : line_stb;
    end

    phase_seq #(.PHASE_LEN(PHASE_LEN), .CAL_LINES(CAL_LINES)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .vblank   (vblank),
        .flip     (phase_flip),
        .cal_red  (cal_red),
        .cal_blue (cal_blue)
    );

    chan_sel i_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .ext_rst (ext_half_rst),
        .kill    (colour_kill),
        .vblank  (vblank),
        .mode    (mode),
        .sel_red (sel_red),
        .gate_r  (gate_red),
        .gate_b  (gate_blue),
        .ident   (ident_en)
    );

    assign line_ref_b = ref_line[0];
    assign line_ref_r = ref_line[1];

    // R9: in crystal mode a lone line strobe leaves the channel select alone
    p_xtal_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal && line_stb && !line_ref_b && !ext_half_rst) |=> $stable(sel_red));

endmodule

// File: tb/test_secam_line_seq.sv
module test_secam_line_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0, vblank = 1'b0, ext_half_rst = 1'b0, colour_kill = 1'b0;
    logic [1:0] tune_mode = 2'b00;
    logic       ref_b_tick = 1'b0, ref_r_tick = 1'b0;
    logic sel_red, gate_red, gate_blue, phase_flip, cal_red, cal_blue, ident_en, line_ref_b, line_ref_r;

    always #2.5 clk = ~clk;

    secam_line_seq i_secam_line_seq (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vblank(vblank),
        .ext_half_rst(ext_half_rst), .colour_kill(colour_kill), .tune_mode(tune_mode),
        .ref_b_tick(ref_b_tick), .ref_r_tick(ref_r_tick),
        .sel_red(sel_red), .gate_red(gate_red), .gate_blue(gate_blue),
        .phase_flip(phase_flip), .cal_red(cal_red), .cal_blue(cal_blue),
        .ident_en(ident_en), .line_ref_b(line_ref_b), .line_ref_r(line_ref_r));

    int n_chk = 0, n_bad = 0, cyc = 0, nb_pulse = 0, nr_pulse = 0;
    bit done = 0;

    // bench model state
    bit m_sel = 1, m_gr = 0, m_gb = 0, m_flip = 0, m_cr = 0, m_cb = 0, m_id = 0;
    bit m_vinv = 0, m_seen = 0;
    int m_cnt = 0, m_pos = 0;

    typedef struct { logic [6:0] v; string tag; } item_t;
    item_t q[$];
    event ev_chk;

    function automatic logic [6:0] outs();
        return {sel_red, gate_red, gate_blue, phase_flip, cal_red, cal_blue, ident_en};
    endfunction

    function automatic logic [6:0] model_vec();
        return {m_sel, m_gr, m_gb, m_flip, m_cr, m_cb, m_id};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic push(input string tag);
        item_t it;
        it.v = model_vec(); it.tag = tag;
        q.push_back(it);
        -> ev_chk;
    endtask

    function automatic void model_step();
        bit first;
        first = vblank && !m_seen;
        m_seen = vblank;
        if (first) begin m_vinv = !m_vinv; m_pos = 1; end
        else if (m_pos != 0) m_pos = (m_pos == 4) ? 0 : m_pos + 1;
        m_flip = (m_cnt == 2) ^ m_vinv;
        m_cnt = (m_cnt + 1) % 3;
        m_sel = !m_sel;
        m_gr = !colour_kill && m_sel;
        m_gb = !colour_kill && !m_sel;
        m_cr = (m_pos == 1 || m_pos == 2);
        m_cb = (m_pos == 3 || m_pos == 4);
        m_id = (tune_mode == 2'b01) && vblank;
    endfunction

    task automatic line(input string tag);
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
        model_step();
        push(tag);
    endtask

    // monitor: compare scoreboard items as they arrive
    initial forever begin
        @(ev_chk);
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, outs(), it.v);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (line_ref_b) nb_pulse++;
        if (line_ref_r) nr_pulse++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int nb0, nr0;
        repeat (3) @(negedge clk);
        check("R10 reset outputs", outs(), 7'b1000000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R3 R7: plain lines
        for (int i = 0; i < 6; i++) line("R1/R3/R7 active line");
        colour_kill = 1'b1;
        for (int i = 0; i < 2; i++) line("R7 kill line");
        colour_kill = 1'b0;
        // R4 R5: blanking interval
        vblank = 1'b1;
        for (int i = 0; i < 6; i++) line("R4/R5 blank line");
        vblank = 1'b0;
        for (int i = 0; i < 3; i++) line("R4 inverted pattern");
        // R6 ident mode in blanking
        tune_mode = 2'b01; vblank = 1'b1;
        for (int i = 0; i < 5; i++) line("R5/R6 ident blank");
        tune_mode = 2'b00;
        @(negedge clk);
        check("R6 ident drops on mode change", ident_en, 1'b0);
        m_id = 0;
        vblank = 1'b0;
        line("R6 no ident");
        // R2 external reset while blue
        if (m_sel) line("R1 to blue");
        @(negedge clk) ext_half_rst = 1'b1;
        @(negedge clk) ext_half_rst = 1'b0;
        m_sel = 1; m_gr = !colour_kill; m_gb = 0;
        push("R2 ext reset forces red");
        line("R2 after ext reset");
        // R8 R9 crystal mode
        tune_mode = 2'b10;
        nb0 = nb_pulse;
        for (int i = 0; i < 271; i++) begin
            @(negedge clk) ref_b_tick = 1'b1;
        end
        @(negedge clk) ref_b_tick = 1'b0;
        @(negedge clk);
        check("R8 no blue pulse at 271", nb_pulse - nb0, 0);
        push("R9 no step before divide");
        @(negedge clk) ref_b_tick = 1'b1;
        @(negedge clk) ref_b_tick = 1'b0;
        @(negedge clk);
        model_step();
        push("R9 crystal step from divider");
        check("R8 blue pulse at 272", nb_pulse - nb0, 1);
        line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
        @(negedge clk);
        push("R9 line_stb ignored in crystal");
        tune_mode = 2'b00;
        nr0 = nr_pulse;
        for (int i = 0; i < 281; i++) begin
            @(negedge clk) ref_r_tick = 1'b1;
        end
        @(negedge clk) ref_r_tick = 1'b0;
        @(negedge clk);
        check("R8 no red pulse at 281", nr_pulse - nr0, 0);
        @(negedge clk) ref_r_tick = 1'b1;
        @(negedge clk) ref_r_tick = 1'b0;
        @(negedge clk);
        check("R8 red pulse at 282", nr_pulse - nr0, 1);
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule